// File: doc/BRIEF.md
# Compare Match Output Toggle

This block sits beside a free-running timer up-counter. It keeps two compare registers and tests each against the counter value on every clock while the timer is running. On the first cycle of equality it raises a one-cycle match flag for that comparator and a shared interrupt pulse.

It also drives a single output flip-flop. The flip-flop inverts when an enabled event occurs. There are four event sources: compare-0 match, compare-1 match, capture-0 latch and capture-1 latch, and each has its own enable bit. While the timer is stopped, software can force the flip-flop through a 2-bit command. The command can invert it, set it or clear it.

All configuration arrives through one register-write port. The port has a 2-bit select and a data word. Select 0 and 1 load the compare registers, select 2 loads the source enables and select 3 issues a flip-flop command.

Top module: `cmp_toggle_top`

## Requirements
- R1: After reset, ffOut, matchFlag and irqPulse are 0, both compare registers hold 0 and all four source enables are 0.
- R2: A write with wrSel 0 or 1 loads the full wrData into compare register 0 or 1. A write with wrSel 2 loads the enables from wrData[3:0]: bit 0 enables compare-0, bit 1 enables compare-1, bit 2 enables capture-0 and bit 3 enables capture-1. The new value is used from the next cycle, and these writes are accepted whether or not the timer runs.
- R3: matchFlag[i] is a one-cycle pulse in the cycle after the first cycle in which running is high and count equals compare register i. No further pulse occurs while that equality persists.
- R4: While running is low, no match is detected and matchFlag stays 0.
- R5: irqPulse is high exactly when at least one bit of matchFlag is high.
- R6: ffOut inverts one cycle after an event whose enable bit is set. An event whose enable is clear has no effect on ffOut.
- R7: When several enabled events occur in the same cycle, ffOut inverts only once.
- R8: A write with wrSel 3 while running is low acts on ffOut in the next cycle, according to wrData[1:0]: 00 inverts it, 01 sets it to 1 and 10 clears it to 0.
- R9: Command 11 leaves ffOut unchanged. Each command acts once, in the cycle of its write, and has no effect afterwards.
- R10: A command write (wrSel 3) while running is high is ignored.
- R11: When a command and an enabled event occur in the same cycle, the command decides the next ffOut and the event is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| running | input | 1 | Timer run status |
| count | input | CNT_W | Up-counter value |
| capPulse | input | 2 | One-cycle capture latch events, bit i for capture register i |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0/1 compare, 2 enables, 3 command |
| wrData | input | CNT_W | Write data |
| irqPulse | output | 1 | Shared compare interrupt pulse |
| matchFlag | output | 2 | Per-comparator match pulse |
| ffOut | output | 1 | Timer output flip-flop level |

## Verification
The bench builds the block with its default 16-bit counter width. In the random phase it keeps counter values and compare values within a 0 to 15 window. This makes matches frequent, so single matches, simultaneous matches, equality held across stalled counter cycles and restarts on an equal count are all reached within a few thousand cycles. Because the counter is full width, a 16-bit compare register that receives a high value is also exercised; such a register never matches in the random phase.

// File: rtl/cmp_toggle_pkg.sv
`timescale 1ns/1ps
package cmp_toggle_pkg;
  localparam int NUM_CMP = 2;
  localparam int NUM_CAP = 2;
  localparam int NUM_SRC = NUM_CMP + NUM_CAP;
  localparam int SEL_W   = 2;
  localparam int CMD_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CMP0 = 2'd0,
    SEL_CMP1 = 2'd1,
    SEL_ENA  = 2'd2,
    SEL_CMD  = 2'd3
  } sel_e;

  typedef enum logic [CMD_W-1:0] {
    CMD_INV = 2'd0,
    CMD_SET = 2'd1,
    CMD_CLR = 2'd2,
    CMD_NOP = 2'd3
  } cmd_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic [NUM_CMP-1:0] ldCmp;
    logic               ldEna;
    logic               doInv;
    logic               doSet;
    logic               doClr;
  } strobe_t;
endpackage

// File: rtl/cmp_toggle_ctrl.sv
`timescale 1ns/1ps
module cmp_toggle_ctrl
  import cmp_toggle_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             running,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [CMD_W-1:0] wrCmd,
  output strobe_t          st
);
  logic cmdOk;

  always_comb begin
    st = '0;
    for (int i = 0; i < NUM_CMP; i++) begin
      st.ldCmp[i] = wrEn && (wrSel == SEL_W'(i));
    end
    st.ldEna = wrEn && (sel_e'(wrSel) == SEL_ENA);
    // commands only while the timer is stopped
    cmdOk = wrEn && (sel_e'(wrSel) == SEL_CMD) && !running;
    case (cmd_e'(wrCmd))
      CMD_INV: st.doInv = cmdOk;
      CMD_SET: st.doSet = cmdOk;
      CMD_CLR: st.doClr = cmdOk;
      default: ;
    endcase
  end

  // R10: command writes during a run produce no strobe
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rstN)
    running |-> !(st.doInv || st.doSet || st.doClr));

  // R9: the no-op command code produces no strobe
  p_nop_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_CMD && wrCmd == CMD_NOP) |-> !(st.doInv || st.doSet || st.doClr));

  // at most one command strobe at a time
  p_one_cmd_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.doInv, st.doSet, st.doClr}));
endmodule

// File: rtl/cmp_toggle_dpath.sv
`timescale 1ns/1ps
module cmp_toggle_dpath
  import cmp_toggle_pkg::*;
#(
  parameter int CNT_W = 16
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               running,
  input  logic [CNT_W-1:0]   count,
  input  logic [NUM_CAP-1:0] capPulse,
  input  logic [CNT_W-1:0]   wrData,
  input  strobe_t            st,
  output logic [NUM_CMP-1:0] matchFlag,
  output logic               irqPulse,
  output logic               ffOut
);
  localparam int ENA_W = NUM_SRC;

  logic [CNT_W-1:0]   cmpReg [NUM_CMP];
  logic [NUM_CMP-1:0] hit;
  logic [NUM_CMP-1:0] prevHit;
  logic [NUM_CMP-1:0] rise;
  logic [ENA_W-1:0]   enaReg;
  logic [ENA_W-1:0]   srcEvt;
  logic               anyEvt;
  logic               anyCmd;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             cmpReg[i] <= '0;
      else if (st.ldCmp[i]) cmpReg[i] <= wrData;
    end

    assign hit[i] = running && (count == cmpReg[i]);

    // R3: a match pulse never lasts two cycles
    p_match_once_r3: assert property (@(posedge clk) disable iff (!rstN)
      matchFlag[i] |=> !matchFlag[i]);
  end

  // first-cycle detection of equality
  assign rise = hit & ~prevHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevHit   <= '0;
      matchFlag <= '0;
      irqPulse  <= 1'b0;
    end else begin
      prevHit   <= hit;
      matchFlag <= rise;
      irqPulse  <= |rise;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         enaReg <= '0;
    else if (st.ldEna) enaReg <= wrData[ENA_W-1:0];
  end

  // source order: compare 0, compare 1, capture 0, capture 1
  assign srcEvt = {capPulse, rise};
  assign anyEvt = |(srcEvt & enaReg);
  assign anyCmd = st.doInv || st.doSet || st.doClr;

  // commands win over hardware events; events collapse into one inversion
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         ffOut <= 1'b0;
    else if (st.doSet) ffOut <= 1'b1;
    else if (st.doClr) ffOut <= 1'b0;
    else if (st.doInv) ffOut <= ~ffOut;
    else if (anyEvt)   ffOut <= ~ffOut;
  end

  // R5: interrupt follows the match flags
  p_irq_any_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse == (|matchFlag));

  // R4: stopped timer reports no match
  p_stopped_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(running) |-> (matchFlag == '0));

  // R7: any number of enabled events gives exactly one inversion
  p_toggle_once_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!anyCmd && anyEvt) |=> (ffOut != $past(ffOut)));

  // R6: without event or command the level holds
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!anyCmd && !anyEvt) |=> $stable(ffOut));

  // R8 and R11: set and clear commands decide the level
  p_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.doSet |=> ffOut);
  p_clr_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.doClr |=> !ffOut);
  p_inv_r11: assert property (@(posedge clk) disable iff (!rstN)
    st.doInv |=> (ffOut != $past(ffOut)));
endmodule

// File: rtl/cmp_toggle_top.sv
`timescale 1ns/1ps
module cmp_toggle_top
  import cmp_toggle_pkg::*;
#(
  parameter int CNT_W = 16
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               running,
  input  logic [CNT_W-1:0]   count,
  input  logic [NUM_CAP-1:0] capPulse,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic [CNT_W-1:0]   wrData,
  output logic               irqPulse,
  output logic [NUM_CMP-1:0] matchFlag,
  output logic               ffOut
);
  strobe_t st;

  cmp_toggle_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .running (running),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrCmd   (wrData[CMD_W-1:0]),
    .st      (st)
  );

  cmp_toggle_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .running   (running),
    .count     (count),
    .capPulse  (capPulse),
    .wrData    (wrData),
    .st        (st),
    .matchFlag (matchFlag),
    .irqPulse  (irqPulse),
    .ffOut     (ffOut)
  );
endmodule

// File: tb/cmp_toggle_top_tb.sv
`timescale 1ns/1ps
module cmp_toggle_top_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        running;
  logic [15:0] count;
  logic [1:0]  capPulse;
  logic        wrEn;
  logic [1:0]  wrSel;
  logic [15:0] wrData;
  logic        irqPulse;
  logic [1:0]  matchFlag;
  logic        ffOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [15:0] mCmp [2];
  logic [3:0]  mEna;
  logic [1:0]  mPrev;
  logic        mFf;
  logic [1:0]  expMatch;
  logic        expIrq;

  always #5 clk = ~clk;

  cmp_toggle_top u_dut (
    .clk(clk), .rstN(rstN), .running(running), .count(count),
    .capPulse(capPulse), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .irqPulse(irqPulse), .matchFlag(matchFlag), .ffOut(ffOut)
  );

  task automatic check(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic nextFf(input logic ff, input logic run, input logic we,
                                  input logic [1:0] sel, input logic [1:0] cmd, input logic evt);
    if (we && sel == 2'd3 && !run) begin
      case (cmd)
        2'd0: return ~ff;
        2'd1: return 1'b1;
        2'd2: return 1'b0;
        default: return evt ? ~ff : ff;
      endcase
    end
    return evt ? ~ff : ff;
  endfunction

  // drive one cycle at the falling edge, predict, check after the rising edge
  task automatic step(input logic run, input logic [15:0] cnt, input logic [1:0] cap,
                      input logic we, input logic [1:0] sel, input logic [15:0] dat, input string tag);
    logic [1:0] h;
    logic [1:0] r;
    logic       evt;
    running = run; count = cnt; capPulse = cap; wrEn = we; wrSel = sel; wrData = dat;
    for (int i = 0; i < 2; i++) h[i] = run && (cnt == mCmp[i]);
    r   = h & ~mPrev;
    evt = |({cap, r} & mEna);
    mFf = nextFf(mFf, run, we, sel, dat[1:0], evt);
    mPrev = h;
    expMatch = r;
    expIrq = |r;
    if (we) begin
      case (sel)
        2'd0: mCmp[0] = dat;
        2'd1: mCmp[1] = dat;
        2'd2: mEna = dat[3:0];
        default: ;
      endcase
    end
    @(posedge clk); #1;
    check(tag, "R3 matchFlag", {2'b0, matchFlag}, {2'b0, expMatch});
    check(tag, "R5 irqPulse", {3'b0, irqPulse}, {3'b0, expIrq});
    check(tag, "R6 ffOut", {3'b0, ffOut}, {3'b0, mFf});
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; running = 0; count = 0; capPulse = 0; wrEn = 0; wrSel = 0; wrData = 0;
    mCmp[0] = 0; mCmp[1] = 0; mEna = 0; mPrev = 0; mFf = 0;
    repeat (3) @(negedge clk);
    check("R1", "reset ffOut", {3'b0, ffOut}, 4'h0);
    check("R1", "reset matchFlag", {2'b0, matchFlag}, 4'h0);
    check("R1", "reset irqPulse", {3'b0, irqPulse}, 4'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: compare registers reset to 0, enables off so no toggle
    step(1, 16'd0, 2'b00, 0, 2'd0, 16'd0, "R1");
    check("R1", "both compares hit zero", {2'b0, matchFlag}, 4'h3);
    step(1, 16'd0, 2'b00, 0, 2'd0, 16'd0, "R3 held equality");
    check("R3", "no repeat pulse", {2'b0, matchFlag}, 4'h0);

    // R2 register loads
    step(0, 16'd0, 2'b00, 1, 2'd0, 16'd5, "R2");
    step(0, 16'd0, 2'b00, 1, 2'd1, 16'd7, "R2");
    step(0, 16'd0, 2'b00, 1, 2'd2, 16'h0003, "R2");
    // R6 compare-driven toggles
    step(1, 16'd4, 2'b00, 0, 2'd0, 16'd0, "R6");
    step(1, 16'd5, 2'b00, 0, 2'd0, 16'd0, "R6");
    check("R6", "toggle on compare-0", {3'b0, ffOut}, 4'h1);
    step(1, 16'd7, 2'b00, 0, 2'd0, 16'd0, "R6");
    check("R6", "toggle on compare-1", {3'b0, ffOut}, 4'h0);
    step(1, 16'd8, 2'b11, 0, 2'd0, 16'd0, "R6 capture disabled");
    check("R6", "disabled capture ignored", {3'b0, ffOut}, 4'h0);

    // R7 four simultaneous enabled events
    step(0, 16'd0, 2'b00, 1, 2'd2, 16'h000F, "R7");
    step(0, 16'd0, 2'b00, 1, 2'd0, 16'd9, "R7");
    step(0, 16'd0, 2'b00, 1, 2'd1, 16'd9, "R7");
    step(1, 16'd9, 2'b11, 0, 2'd0, 16'd0, "R7");
    check("R7", "single inversion", {3'b0, ffOut}, 4'h1);

    // R4 stopped timer
    step(0, 16'd9, 2'b00, 0, 2'd0, 16'd0, "R4");
    check("R4", "no match when stopped", {2'b0, matchFlag}, 4'h0);

    // R8 commands
    step(0, 16'd0, 2'b00, 1, 2'd3, 16'h0002, "R8 clear");
    check("R8", "clear", {3'b0, ffOut}, 4'h0);
    step(0, 16'd0, 2'b00, 1, 2'd3, 16'h0001, "R8 set");
    check("R8", "set", {3'b0, ffOut}, 4'h1);
    step(0, 16'd0, 2'b00, 1, 2'd3, 16'h0000, "R8 invert");
    check("R8", "invert", {3'b0, ffOut}, 4'h0);
    // R9 no-op and single action
    step(0, 16'd0, 2'b00, 1, 2'd3, 16'h0003, "R9 nop");
    check("R9", "nop keeps level", {3'b0, ffOut}, 4'h0);
    step(0, 16'd0, 2'b00, 1, 2'd3, 16'h0000, "R9");
    step(0, 16'd0, 2'b00, 0, 2'd0, 16'd0, "R9 once");
    check("R9", "command acts once", {3'b0, ffOut}, 4'h1);
    // R10 command while running
    step(1, 16'd20, 2'b00, 1, 2'd3, 16'h0002, "R10");
    check("R10", "running command ignored", {3'b0, ffOut}, 4'h1);
    // R11 command beats event
    step(0, 16'd0, 2'b01, 1, 2'd3, 16'h0002, "R11");
    check("R11", "clear wins over capture", {3'b0, ffOut}, 4'h0);
    step(0, 16'd0, 2'b10, 1, 2'd3, 16'h0000, "R11 invert");
    check("R11", "invert once with capture", {3'b0, ffOut}, 4'h1);

    // random phase
    begin
      logic [15:0] cnt = 16'd0;
      logic        run = 1'b1;
      for (int n = 0; n < 3000; n++) begin
        logic [1:0]  cap;
        logic        we;
        logic [1:0]  sel;
        logic [15:0] dat;
        if (($urandom % 10) == 0) run = ~run;
        if (($urandom % 5) != 0) cnt = (cnt + 16'd1) & 16'h000F;
        cap = (($urandom % 6) == 0) ? 2'($urandom) : 2'b00;
        we  = (($urandom % 5) == 0);
        sel = 2'($urandom);
        dat = (($urandom % 20) == 0) ? 16'($urandom) : 16'($urandom % 16);
        step(run, cnt, cap, we, sel, dat, "RND");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule